// File: doc/BRIEF.md
# Page-Load Buffer with Timeout

This block gathers byte writes from a host into a one-page staging buffer and then commits the whole page to a storage array in one operation. A page is 2^COL_W bytes wide, 128 by default. The low COL_W address bits pick the column inside the page. The remaining upper bits name the page. Each accepted byte is stored in the buffer, marks its column as loaded and restarts an inactivity counter. The page address is taken from the last byte loaded.

When GAP_CYC clock cycles pass with no further byte, the block closes the page and raises `busy` for COMMIT_CYC cycles. At the end of that time, every column of the page is written to the array in the same clock edge. Loaded columns carry the user data and unloaded columns carry all-ones. The buffer then forgets all loaded columns. While `busy` is high, write and read strobes are dropped. At other times a read returns the array byte one cycle later, flagged by `rvalid`.

The array is a register model that resets to all-ones, which is the erased state. Both time limits are cycle-count parameters, so the host chooses the clock rate that maps them onto real time.

Top module: `pgl_top`

## Requirements
- R1: After reset `busy` and `rvalid` are 0, and every array byte reads as FFh.
- R2: A byte loaded at address A lands, after the commit, at column A[COL_W-1:0] of page A[ADDR_W-1:COL_W].
- R3: Every column of the committed page that received no byte since the previous commit is written as FFh.
- R4: A second byte loaded to the same column before the page closes replaces the first one.
- R5: All buffered bytes are committed into the page named by the last byte loaded. A page named only by earlier bytes keeps its old contents.
- R6: A byte arriving at most GAP_CYC-1 cycles after the previous accepted byte keeps the page open. There is no limit on the number of bytes or on the total load time.
- R7: `busy` rises exactly GAP_CYC clock edges after the edge that accepted the last byte, provided no byte arrives in between.
- R8: `busy` stays high for exactly COMMIT_CYC cycles. The array holds the new page in the cycle after `busy` falls.
- R9: A write strobe while `busy` is high changes neither the array nor the buffer, and it does not reopen a page.
- R10: After a commit the buffer holds no loaded columns, so data from an earlier page-write never reappears in a later one.
- R11: A read strobe while `busy` is low gives `rvalid` and the array byte on the next cycle. A read strobe while `busy` is high gives no `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Byte-load strobe, one cycle per byte |
| rd_req | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for load or read; upper bits are the page |
| wdata | input | DATA_W | Byte to load |
| rdata | output | DATA_W | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| busy | output | 1 | Internal page commit in progress |

## Verification
The bound checker watches the edge of the block on every cycle. It measures the quiet time before each rise of `busy`, which must be exactly GAP_CYC and must follow a real load. It measures the length of every `busy` period and checks that no page closes early while bytes keep arriving. It also checks that each accepted read produces exactly one `rvalid` and that a blocked read produces none. The bench scenarios are the only way to show what actually reaches the array: column placement, overwrite of a column, FFh fill of unloaded columns, the page that follows the last byte, dropped strobes while busy, and the clearing of the buffer between page-writes.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOAD   = 2'd1,
      ST_COMMIT = 2'd2
   } pgl_state_e;
endpackage

// File: rtl/pgl_page_buf.sv
module pgl_page_buf #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 7,
   localparam int COLS  = 1 << COL_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_en,
   input  logic [COL_W-1:0]              ld_col,
   input  logic [DATA_W-1:0]             ld_data,
   input  logic                          clr,
   output logic [COLS-1:0][DATA_W-1:0]   row_q,
   output logic [COLS-1:0]               mask_q
);
   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic hit;
      assign hit = ld_en && (ld_col == COL_W'(c));

      // data bytes need no reset: the mask decides whether they are used
      always_ff @(posedge clk) begin
         if (hit) row_q[c] <= ld_data;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     mask_q[c] <= 1'b0;
         else if (clr)   mask_q[c] <= 1'b0;
         else if (hit)   mask_q[c] <= 1'b1;
      end
   end
endmodule

// File: rtl/pgl_seq.sv
module pgl_seq
   import pgl_pkg::*;
#(
   parameter int GAP_CYC    = 40000,
   parameter int COMMIT_CYC = 1000000,
   parameter int PAGE_W     = 3,
   localparam int GW = $clog2(GAP_CYC + 1),
   localparam int KW = $clog2(COMMIT_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [PAGE_W-1:0] wr_page,
   output logic              ld_en,
   output logic              commit_we,
   output logic [PAGE_W-1:0] commit_page,
   output logic              busy
);
   pgl_state_e        state_q;
   logic [GW-1:0]     gap_q;
   logic [KW-1:0]     hold_q;
   logic [PAGE_W-1:0] page_q;
   logic              gap_done;
   logic              hold_done;

   assign busy        = (state_q == ST_COMMIT);
   assign ld_en       = wr_req && !busy;
   assign gap_done    = (gap_q == GW'(GAP_CYC - 1));
   assign hold_done   = (hold_q == KW'(COMMIT_CYC - 1));
   assign commit_we   = busy && hold_done;
   assign commit_page = page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         gap_q   <= '0;
         hold_q  <= '0;
         page_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (ld_en) begin
                  state_q <= ST_LOAD;
                  gap_q   <= '0;
                  page_q  <= wr_page;
               end
            end
            ST_LOAD: begin
               if (ld_en) begin
                  gap_q  <= '0;
                  page_q <= wr_page;
               end else if (gap_done) begin
                  state_q <= ST_COMMIT;
                  hold_q  <= '0;
               end else begin
                  gap_q <= gap_q + GW'(1);
               end
            end
            ST_COMMIT: begin
               if (hold_done) state_q <= ST_IDLE;
               else           hold_q  <= hold_q + KW'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgl_store.sv
module pgl_store #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 7,
   parameter int PAGE_W = 3,
   localparam int COLS  = 1 << COL_W,
   localparam int PAGES = 1 << PAGE_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [PAGE_W-1:0]           wpage,
   input  logic [COLS-1:0][DATA_W-1:0] wrow,
   input  logic                        rd_en,
   input  logic [PAGE_W-1:0]           rpage,
   input  logic [COL_W-1:0]            rcol,
   output logic [DATA_W-1:0]           rdata,
   output logic                        rvalid
);
   logic [COLS-1:0][DATA_W-1:0] mem [PAGES];

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n)                             mem[p] <= '1;
         else if (we && (wpage == PAGE_W'(p)))   mem[p] <= wrow;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) rdata <= mem[rpage][rcol];
      end
   end
endmodule

// File: rtl/pgl_top.sv
module pgl_top #(
   parameter int DATA_W     = 8,
   parameter int COL_W      = 7,
   parameter int ADDR_W     = 10,
   parameter int GAP_CYC    = 40000,
   parameter int COMMIT_CYC = 1000000,
   localparam int COLS   = 1 << COL_W,
   localparam int PAGE_W = ADDR_W - COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              busy
);
   if (DATA_W < 1)       $error("pgl_top: DATA_W must be at least 1");
   if (COL_W < 1)        $error("pgl_top: COL_W must be at least 1");
   if (ADDR_W <= COL_W)  $error("pgl_top: ADDR_W must exceed COL_W");
   if (GAP_CYC < 2)      $error("pgl_top: GAP_CYC must be at least 2");
   if (COMMIT_CYC < 1)   $error("pgl_top: COMMIT_CYC must be at least 1");

   logic [COL_W-1:0]            col;
   logic [PAGE_W-1:0]           page;
   logic                        ld_en;
   logic                        commit_we;
   logic [PAGE_W-1:0]           commit_page;
   logic [COLS-1:0][DATA_W-1:0] buf_row;
   logic [COLS-1:0]             buf_mask;
   logic [COLS-1:0][DATA_W-1:0] commit_row;

   assign col  = addr[COL_W-1:0];
   assign page = addr[ADDR_W-1:COL_W];

   pgl_seq #(
      .GAP_CYC    (GAP_CYC),
      .COMMIT_CYC (COMMIT_CYC),
      .PAGE_W     (PAGE_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_req      (wr_req),
      .wr_page     (page),
      .ld_en       (ld_en),
      .commit_we   (commit_we),
      .commit_page (commit_page),
      .busy        (busy)
   );

   pgl_page_buf #(
      .DATA_W (DATA_W),
      .COL_W  (COL_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_col  (col),
      .ld_data (wdata),
      .clr     (commit_we),
      .row_q   (buf_row),
      .mask_q  (buf_mask)
   );

   // unloaded columns are committed in the erased state
   for (genvar c = 0; c < COLS; c++) begin : g_fill
      assign commit_row[c] = buf_mask[c] ? buf_row[c] : {DATA_W{1'b1}};
   end

   pgl_store #(
      .DATA_W (DATA_W),
      .COL_W  (COL_W),
      .PAGE_W (PAGE_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (commit_we),
      .wpage  (commit_page),
      .wrow   (commit_row),
      .rd_en  (rd_req && !busy),
      .rpage  (page),
      .rcol   (col),
      .rdata  (rdata),
      .rvalid (rvalid)
   );
endmodule

// File: rtl/pgl_chk.sv
module pgl_chk #(
   parameter int GAP_CYC    = 40000,
   parameter int COMMIT_CYC = 1000000,
   localparam int QW = $clog2(GAP_CYC + 2),
   localparam int RW = $clog2(COMMIT_CYC + 2)
) (
   input logic clk,
   input logic rst_n,
   input logic wr_req,
   input logic rd_req,
   input logic rvalid,
   input logic busy
);
   logic [QW-1:0] quiet_q;
   logic [RW-1:0] run_q;

   // cycles since the last accepted byte; saturates at GAP_CYC+1 ("no open page")
   always_ff @(posedge clk) begin
      if (!rst_n)                          quiet_q <= QW'(GAP_CYC + 1);
      else if (wr_req && !busy)            quiet_q <= '0;
      else if (quiet_q < QW'(GAP_CYC + 1)) quiet_q <= quiet_q + QW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + RW'(1);
      else           run_q <= '0;
   end

   assert_gap_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (quiet_q == QW'(GAP_CYC)));

   assert_open_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (quiet_q < QW'(GAP_CYC - 1))) |=> !busy);

   assert_commit_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == RW'(COMMIT_CYC)));

   assert_commit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RW'(COMMIT_CYC)));

   assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !busy) |=> rvalid);

   assert_rd_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(rd_req && !busy));
endmodule

bind pgl_top pgl_chk #(
   .GAP_CYC    (GAP_CYC),
   .COMMIT_CYC (COMMIT_CYC)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_req (wr_req),
   .rd_req (rd_req),
   .rvalid (rvalid),
   .busy   (busy)
);

// File: tb/pgl_top_tb.sv
module pgl_top_tb;
   localparam int DW     = 8;
   localparam int CW     = 7;
   localparam int AW     = 10;
   localparam int GAP    = 8;
   localparam int COMMIT = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic          rd_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;
   logic          busy;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #2.5 clk = ~clk;

   pgl_top #(
      .DATA_W (DW), .COL_W (CW), .ADDR_W (AW),
      .GAP_CYC (GAP), .COMMIT_CYC (COMMIT)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .wr_req (wr_req), .rd_req (rd_req),
      .addr (addr), .wdata (wdata), .rdata (rdata), .rvalid (rvalid),
      .busy (busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int page, input int col, input logic [DW-1:0] d);
      @(negedge clk);
      wr_req = 1'b1;
      addr   = AW'((page << CW) | col);
      wdata  = d;
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   // driver: push the expected byte, the monitor compares when rvalid shows
   task automatic rd(input int page, input int col, input logic [DW-1:0] e, input string req);
      @(negedge clk);
      rd_req = 1'b1;
      addr   = AW'((page << CW) | col);
      exp_q.push_back(e);
      tag_q.push_back(req);
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic rd_blocked(input int page, input int col);
      @(negedge clk);
      rd_req = 1'b1;
      addr   = AW'((page << CW) | col);
      @(negedge clk);
      rd_req = 1'b0;
      chk("R11 read while busy gives no rvalid", int'(rvalid), 0);
   endtask

   // called right after the last wr(): checks close timing and commit length
   task automatic close_and_commit(input string tag);
      int n;
      repeat (GAP - 1) @(negedge clk);
      chk({"R7 still open one cycle before close ", tag}, int'(busy), 0);
      @(negedge clk);
      chk({"R7 busy rises at close ", tag}, int'(busy), 1);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
      chk({"R8 busy length ", tag}, n, COMMIT);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R11: actual=rvalid expected=no rvalid");
            end else begin
               automatic logic [DW-1:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               chk(t, int'(rdata), int'(e));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 rvalid after reset", int'(rvalid), 0);
      rd(0, 5, 8'hFF, "R1 erased byte");
      rd(7, 127, 8'hFF, "R1 erased last byte");

      // page 2: two columns, one overwritten
      wr(2, 3, 8'h11);
      wr(2, 127, 8'h22);
      wr(2, 3, 8'h33);
      close_and_commit("page 2");
      rd(2, 3, 8'h33, "R4 overwrite wins");
      rd(2, 127, 8'h22, "R2 column placement");
      rd(2, 0, 8'hFF, "R3 unloaded column");
      rd(1, 3, 8'hFF, "R2 other page untouched");

      // spaced loads just inside the window
      for (int i = 0; i < 5; i++) begin
         wr(1, i, DW'(8'h40 + i));
         if (i < 4) begin
            repeat (GAP - 3) @(negedge clk);
            chk("R6 page stays open", int'(busy), 0);
         end
      end
      close_and_commit("spaced");
      for (int i = 0; i < 5; i++) rd(1, i, DW'(8'h40 + i), "R6 every byte kept");
      rd(1, 5, 8'hFF, "R3 tail column");

      // page follows last byte; strobes while busy are dropped
      wr(3, 10, 8'hA5);
      wr(5, 11, 8'h5A);
      while (!busy) @(negedge clk);
      wr(6, 0, 8'h77);
      rd_blocked(6, 0);
      while (busy) @(negedge clk);
      repeat (GAP + 4) @(negedge clk);
      chk("R9 dropped strobe opens no page", int'(busy), 0);
      rd(5, 10, 8'hA5, "R5 earlier byte moved to last page");
      rd(5, 11, 8'h5A, "R5 last byte");
      rd(3, 10, 8'hFF, "R5 first page untouched");
      rd(6, 0, 8'hFF, "R9 dropped byte not stored");
      rd(5, 0, 8'hFF, "R9 dropped byte not buffered");

      // buffer cleared between page-writes
      wr(2, 5, 8'h44);
      close_and_commit("reload");
      rd(2, 5, 8'h44, "R10 new byte");
      rd(2, 3, 8'hFF, "R10 stale byte gone");
      rd(2, 127, 8'hFF, "R10 stale tail gone");

      repeat (4) @(negedge clk);
      chk("R11 all reads answered", exp_q.size(), 0);
      finished = 1'b1;
      summary();
   end
endmodule